// File: doc/BRIEF.md
# Dynamic-Key Secure Scan Controller

This block puts a key check in front of a serial scan chain. Every test pattern shifted in carries two extra fields: a seed at its head and a key at its tail. While the pattern shifts in, the controller loads the seed into a small key generator and advances it a fixed number of steps. On the last shift it compares the generated key with the key bits that just arrived. The unlock key is never held in storage. It is rebuilt from the seed of each pattern, so every pattern needs its own key.

When the key matches, the next capture pulse applies the shifted pattern to the logic under test. One cycle later the controller records that logic's response, and the next shift window sends the response out on the scan output. When the key does not match, the capture pulse leaves the applied pattern unchanged and records nothing. The scan output then carries a pseudo-response from a second generator. That generator is reseeded from the failed key bits, so wrong guesses still see plausible, varying data instead of a blocked port. The applied pattern register drives the functional logic and changes only on an authorized capture.

Top module: `dkscan_ctrl`

## Requirements
- R1: Synchronous active-high reset clears `stim_q` and `scan_out` to zero, leaves no response readable, loads the pseudo-response state with 16'hACE1 and loads the key generator with 9'h1FF.
- R2: Each cycle with `scan_enable` high shifts `scan_in` into the chain. After a pattern of CHAIN_LEN bits, the first bit shifted in sits at chain bit CHAIN_LEN-1.
- R3: The first 9 bits of a window load the key generator, first bit as MSB. The next 16 shift cycles each step it as s <= {s[7:0], s[8]^s[4]}. On shift number CHAIN_LEN, the last 9 bits received (first of them as MSB) are compared with the generated key. The pattern is authorized only if they are equal and the key is non-zero.
- R4: A `capture` pulse with `scan_enable` low and authorization held copies the chain into `stim_q` on that edge. On the following edge the controller records `func_d` as the response.
- R5: A `capture` pulse without authorization leaves `stim_q` unchanged and makes any previously recorded response unreadable.
- R6: If a response is readable, each shift cycle of the next window drives the next response bit, MSB first, onto `scan_out`. The bit becomes visible after the shift edge.
- R7: If no response is readable, each shift cycle drives bit 15 of the pseudo-response state onto `scan_out` and then steps that state as s <= {s[14:0], s[15]^s[14]^s[12]^s[3]}. On an unauthorized comparison the state is reseeded instead, to {7'b1010011, received key}.
- R8: Authorization is single use. It is cleared by an authorized capture, by the first shift of a new window, and by any shift beyond CHAIN_LEN in the same window.
- R9: A recorded response can be read in one window only. The comparison shift of any window makes it unreadable.
- R10: `scan_out` is low in every cycle after an edge at which `scan_enable` was low, and `capture` is ignored while `scan_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_enable | input | 1 | High for each shift cycle |
| scan_in | input | 1 | Serial pattern input |
| capture | input | 1 | Apply-and-capture pulse, honoured with scan_enable low |
| func_d | input | CHAIN_LEN | Response of the logic under test |
| stim_q | output | CHAIN_LEN | Applied pattern that drives the logic under test |
| scan_out | output | 1 | Registered serial output: true or pseudo response |

## Verification
The bench builds the controller with CHAIN_LEN = 32. That length leaves 14 free pattern bits between the 9-bit seed and the 9-bit key, so the 16 generator steps finish well before the comparison shift. With this length, every one of the nine single-bit key errors can be run in turn, each with its own pseudo-response reseed. The same setup reaches the overrun shift past the window, the all-zero seed and key, a double capture, and reading one response twice.

// File: rtl/dks_pkg.sv
package dks_pkg;
  localparam int KEY_W     = 9;
  localparam int KEY_STEPS = 16;
  localparam int PRS_W     = 16;
  localparam logic [KEY_W-1:0]       KEY_RST = 9'h1FF;
  localparam logic [PRS_W-1:0]       PRS_RST = 16'hACE1;
  localparam logic [PRS_W-KEY_W-1:0] PRS_PAD = 7'b1010011;

  function automatic logic [KEY_W-1:0] key_next(input logic [KEY_W-1:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [PRS_W-1:0] prs_next(input logic [PRS_W-1:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction
endpackage

// File: rtl/dks_keygen.sv
module dks_keygen
  import dks_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             step_en,
  input  logic             din,
  output logic [KEY_W-1:0] key_q
);
  always_ff @(posedge clk) begin
    if (rst)          key_q <= KEY_RST;
    else if (load_en) key_q <= {key_q[KEY_W-2:0], din};
    else if (step_en) key_q <= key_next(key_q);
  end

  // R3: the generated key only moves while loading or stepping
  assert_key_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(key_q));
endmodule

// File: rtl/dks_prgen.sv
module dks_prgen
  import dks_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_en,
  input  logic [KEY_W-1:0] seed,
  input  logic             step_en,
  output logic             out_bit
);
  logic [PRS_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst)          st_q <= PRS_RST;
    else if (seed_en) st_q <= {PRS_PAD, seed};
    else if (step_en) st_q <= prs_next(st_q);
  end

  assign out_bit = st_q[PRS_W-1];

  // R7: the pad keeps the pseudo-response state away from the lock-up value
  assert_prs_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
endmodule

// File: rtl/dks_chain.sv
module dks_chain
  import dks_pkg::*;
#(
  parameter int CHAIN_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 din,
  input  logic                 apply_en,
  input  logic                 load_rsp,
  input  logic                 rsp_shift,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] stim_q,
  output logic [KEY_W-2:0]     tail,
  output logic                 rsp_msb
);
  logic [CHAIN_LEN-1:0] sh_q;
  logic [CHAIN_LEN-1:0] rsp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      stim_q <= '0;
      rsp_q  <= '0;
    end else begin
      if (shift_en) sh_q <= {sh_q[CHAIN_LEN-2:0], din};
      if (apply_en) stim_q <= sh_q;
      if (load_rsp)       rsp_q <= func_d;
      else if (rsp_shift) rsp_q <= {rsp_q[CHAIN_LEN-2:0], 1'b0};
    end
  end

  assign tail    = sh_q[KEY_W-2:0];
  assign rsp_msb = rsp_q[CHAIN_LEN-1];

  // R5: the functional side sees a new pattern only on an apply
  assert_stim_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !apply_en |=> $stable(stim_q));
endmodule

// File: rtl/dkscan_ctrl.sv
module dkscan_ctrl
  import dks_pkg::*;
#(
  parameter int CHAIN_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_enable,
  input  logic                 scan_in,
  input  logic                 capture,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] stim_q,
  output logic                 scan_out
);
  localparam int CNT_W = $clog2(CHAIN_LEN + 1);
  localparam logic [CNT_W-1:0] SEED_END = CNT_W'(KEY_W);
  localparam logic [CNT_W-1:0] STEP_END = CNT_W'(KEY_W + KEY_STEPS);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(CHAIN_LEN - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(CHAIN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             auth_q, pend_q, rok_q, so_q;
  logic [KEY_W-1:0] kg_q, key_rx;
  logic [KEY_W-2:0] tail;
  logic             rsp_msb, prs_bit;
  logic             kg_load, kg_step, win_end, overrun, match;
  logic             cap_go, cap_bad, prs_seed, prs_step, rsp_shift;

  assign key_rx    = {tail, scan_in};
  assign kg_load   = scan_enable && (cnt_q < SEED_END);
  assign kg_step   = scan_enable && (cnt_q >= SEED_END) && (cnt_q < STEP_END);
  assign win_end   = scan_enable && (cnt_q == LAST);
  assign overrun   = scan_enable && (cnt_q == FULL);
  assign match     = (key_rx == kg_q) && (kg_q != '0);
  assign cap_go    = capture && !scan_enable && auth_q;
  assign cap_bad   = capture && !scan_enable && !auth_q;
  assign prs_seed  = win_end && !match;
  assign prs_step  = scan_enable && !rok_q && !prs_seed;
  assign rsp_shift = scan_enable && rok_q;

  dks_keygen u_keygen (
    .clk(clk), .rst(rst), .load_en(kg_load), .step_en(kg_step),
    .din(scan_in), .key_q(kg_q)
  );

  dks_prgen u_prgen (
    .clk(clk), .rst(rst), .seed_en(prs_seed), .seed(key_rx),
    .step_en(prs_step), .out_bit(prs_bit)
  );

  dks_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk(clk), .rst(rst), .shift_en(scan_enable), .din(scan_in),
    .apply_en(cap_go), .load_rsp(pend_q), .rsp_shift(rsp_shift),
    .func_d(func_d), .stim_q(stim_q), .tail(tail), .rsp_msb(rsp_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      auth_q <= 1'b0;
      pend_q <= 1'b0;
      rok_q  <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      so_q   <= scan_enable ? (rok_q ? rsp_msb : prs_bit) : 1'b0;
      pend_q <= cap_go;
      if (!scan_enable)      cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      if (win_end) auth_q <= match;
      else if ((scan_enable && cnt_q == '0) || overrun || cap_go) auth_q <= 1'b0;
      if (pend_q) rok_q <= 1'b1;
      else if (win_end || cap_bad) rok_q <= 1'b0;
    end
  end

  assign scan_out = so_q;

  // R8: an authorized capture consumes the authorization
  assert_auth_once_R8: assert property (@(posedge clk) disable iff (rst)
    (capture && !scan_enable && auth_q) |=> !auth_q);
  // R10: the serial output rests low outside shift cycles
  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !scan_enable |=> !scan_out);
  // R4: a response becomes readable only right after an apply
  assert_rsp_src_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rok_q) |-> $past(pend_q));
  // R8: a new window never starts authorized after its first shift
  assert_new_win_R8: assert property (@(posedge clk) disable iff (rst)
    (scan_enable && cnt_q == '0) |=> !auth_q);
endmodule

// File: tb/dkscan_ctrl_tb_top.sv
module dkscan_ctrl_tb_top;
  localparam int N = 32;
  localparam logic [N-1:0] FMASK = 32'hC3A5_5A3C;

  logic clk = 1'b0, rst = 1'b1;
  logic se = 1'b0, si = 1'b0, cap = 1'b0;
  logic [N-1:0] func_d, stim_q;
  logic scan_out;

  always #2.5 clk = ~clk;

  dkscan_ctrl #(.CHAIN_LEN(N)) dut_i (
    .clk(clk), .rst(rst), .scan_enable(se), .scan_in(si), .capture(cap),
    .func_d(func_d), .stim_q(stim_q), .scan_out(scan_out)
  );

  function automatic logic [N-1:0] fut(input logic [N-1:0] s);
    return {s[N-2:0], s[N-1]} ^ FMASK;
  endfunction
  assign func_d = fut(stim_q);

  function automatic logic [8:0] kstep(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction
  function automatic logic [15:0] pstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction
  function automatic logic [8:0] key_of(input logic [8:0] seed);
    logic [8:0] s = seed;
    for (int i = 0; i < 16; i++) s = kstep(s);
    return s;
  endfunction
  function automatic logic [N-1:0] mkpat(input logic [8:0] seed, input logic [N-19:0] mid);
    return {seed, mid, key_of(seed)};
  endfunction

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference, updated on every edge from the inputs only
  logic [N-1:0] m_sh, m_stim, m_rsp;
  logic [8:0]   m_kg;
  logic [15:0]  m_prs;
  int           m_cnt;
  logic m_auth, m_pend, m_rok, m_so, m_shifted;
  logic [N-1:0] got;

  always @(posedge clk) begin
    if (rst) begin
      m_sh = '0; m_stim = '0; m_rsp = '0; m_kg = 9'h1FF; m_prs = 16'hACE1;
      m_cnt = 0; m_auth = 0; m_pend = 0; m_rok = 0; m_so = 0; m_shifted = 0;
    end else begin
      logic o_rok, o_pend, o_auth, we, mt;
      logic [8:0] krx;
      int oc;
      o_rok = m_rok; o_pend = m_pend; o_auth = m_auth; oc = m_cnt;
      we  = se && (oc == N-1);
      krx = {m_sh[7:0], si};
      mt  = (krx == m_kg) && (m_kg != 0);
      m_so = se ? (o_rok ? m_rsp[N-1] : m_prs[15]) : 1'b0;
      if (o_pend) m_rsp = fut(m_stim);
      else if (se && o_rok) m_rsp = m_rsp << 1;
      if (we && !mt) m_prs = {7'b1010011, krx};
      else if (se && !o_rok) m_prs = pstep(m_prs);
      if (se && oc < 9) m_kg = {m_kg[7:0], si};
      else if (se && oc < 25) m_kg = kstep(m_kg);
      if (we) m_auth = mt;
      else if ((se && oc == 0) || (se && oc == N) || (cap && !se && o_auth)) m_auth = 0;
      m_pend = cap && !se && o_auth;
      if (m_pend) m_stim = m_sh;
      if (o_pend) m_rok = 1;
      else if (we || (cap && !se && !o_auth)) m_rok = 0;
      if (se) m_sh = {m_sh[N-2:0], si};
      if (!se) m_cnt = 0; else if (oc != N) m_cnt = oc + 1;
      m_shifted = se;
    end
  end

  // Per-cycle comparison against the reference (R2 R6 R7 R10)
  always @(negedge clk) begin
    if (!rst) begin
      chk(scan_out === m_so, "R2 R6 R7 R10 scan_out per cycle", N'(scan_out), N'(m_so));
      chk(stim_q === m_stim, "R4 R5 stim_q per cycle", stim_q, m_stim);
      if (m_shifted) got = {got[N-2:0], scan_out};
    end
  end

  task automatic shift_pat(input logic [N-1:0] p, input int extra);
    got = '0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk); se = 1'b1; si = p[N-1-i];
    end
    for (int i = 0; i < extra; i++) begin
      @(negedge clk); si = 1'b0;
    end
    @(negedge clk); se = 1'b0; si = 1'b0;
    #1;
  endtask

  task automatic do_capture();
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    @(negedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] prs_seq(input logic [15:0] start);
    logic [15:0] s = start;
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin v[N-1-i] = s[15]; s = pstep(s); end
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] p1, p2, p3, bad, keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(scan_out == 1'b0, "R1 scan_out after reset", N'(scan_out), '0);
    chk(stim_q == '0, "R1 stim_q after reset", stim_q, '0);

    // R1 R7: first window with a wrong key shows the reset pseudo sequence
    shift_pat({9'h0A5, 14'h1234, 9'h000}, 0);
    chk(got == prs_seq(16'hACE1), "R1 R7 first pseudo window", got, prs_seq(16'hACE1));
    @(negedge clk); #1;
    chk(scan_out == 1'b0, "R10 idle low after window", N'(scan_out), '0);

    // R3 R4: matching seed and key apply the pattern
    p1 = mkpat(9'h13B, 14'h2A5C);
    shift_pat(p1, 0);
    do_capture();
    chk(stim_q == p1, "R3 R4 authorized apply", stim_q, p1);

    // R6: the next window reads the true response
    p2 = mkpat(9'h0C7, 14'h0F0F);
    shift_pat(p2, 0);
    chk(got == fut(p1), "R6 true response out", got, fut(p1));
    do_capture();
    chk(stim_q == p2, "R4 second authorized apply", stim_q, p2);

    // R5 R7: every single-bit key error
    p3 = mkpat(9'h1E2, 14'h3333);
    for (int b = 0; b < 9; b++) begin
      bad = p3 ^ (N'(1) << b);
      shift_pat(bad, 0);
      if (b == 0) chk(got == fut(p2), "R6 response of p2", got, fut(p2));
      else chk(got != fut(p2), "R7 pseudo never true data", got, fut(p2));
      do_capture();
      chk(stim_q == p2, "R5 wrong key keeps stim", stim_q, p2);
    end
    shift_pat(p3 ^ N'(1), 0);
    chk(got == prs_seq({7'b1010011, key_of(9'h1E2) ^ 9'h100}), "R7 reseed from bad key",
        got, prs_seq({7'b1010011, key_of(9'h1E2) ^ 9'h100}));

    // R3: all-zero seed and key never authorize
    shift_pat('0, 0);
    do_capture();
    chk(stim_q == p2, "R3 zero key rejected", stim_q, p2);

    // R8: shifting past the window drops authorization
    keep = mkpat(9'h055, 14'h1111);
    shift_pat(keep, 1);
    do_capture();
    chk(stim_q == p2, "R8 overrun drops auth", stim_q, p2);

    // R8: second capture finds no authorization and hides the response
    p1 = mkpat(9'h1A0, 14'h0ABC);
    shift_pat(p1, 0);
    do_capture();
    chk(stim_q == p1, "R4 apply before double capture", stim_q, p1);
    do_capture();
    shift_pat('0, 0);
    chk(got != fut(p1), "R8 second capture hides response", got, fut(p1));

    // R9: a response is readable once
    p2 = mkpat(9'h0FE, 14'h2222);
    shift_pat(p2, 0);
    do_capture();
    shift_pat('0, 0);
    chk(got == fut(p2), "R9 first read true", got, fut(p2));
    shift_pat('0, 0);
    chk(got != fut(p2), "R9 second read pseudo", got, fut(p2));

    // R10: capture during shifting is ignored
    p3 = mkpat(9'h111, 14'h0707);
    shift_pat(p3, 0);
    @(negedge clk); se = 1'b1; cap = 1'b1;
    @(negedge clk); se = 1'b0; cap = 1'b0;
    #1;
    chk(stim_q == p2, "R10 capture ignored while shifting", stim_q, p2);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule